// File: doc/BRIEF.md
# Serial Port Buffer and Interrupt Unit

This block sits between a clocked serial shift engine and the CPU register bus. It holds one transmit and one receive FIFO, each 32 bytes deep. The CPU pushes transmit words through a write window and pops receive words through a read window. The shift engine takes transmit words and delivers received words through single-cycle strobes. The unit runs in byte mode or in 16-bit mode. In 16-bit mode every entry uses two bytes of capacity, and the level registers still count bytes.

The interrupt unit keeps six sticky event flags in a status register, and software clears them by writing ones. The same bit positions in the control register enable each flag onto one level-sensitive interrupt line. The receive-trigger flag compares the receive occupancy against a threshold of 2^n words, where n is a 3-bit code. A separate control bit gates this flag.

Registers are addressed by a 3-bit word index: 0 control, 1 status, 2 receive level, 3 transmit level, 4 receive window, 5 transmit window, 6 trigger code. In the control register, bit 19 is the receive-trigger gate, bit 24 selects 16-bit mode, and bits 13, 12, 9, 8, 4 and 0 are the interrupt enables.

Top module: `serbuf_irq_unit`

## Requirements
- R1: The transmit and receive FIFOs each hold 32 bytes: 32 entries in byte mode, 16 entries in 16-bit mode (control bit 24 = 1). A push into a full FIFO is dropped.
- R2: Reading index 2 returns the receive occupancy in bytes, and reading index 3 returns the transmit occupancy in bytes. In 16-bit mode this is twice the entry count.
- R3: A write of any value to index 2 or index 3 empties the receive or transmit FIFO respectively.
- R4: A write to index 5 pushes the low 8 bits of the write data, or the low 16 bits in 16-bit mode. The engine sees the oldest word on txWord, and txPopReq removes it.
- R5: A read of index 4 returns the oldest received word, zero-extended, and removes it. A read when the receive FIFO is empty returns 0. A received word is masked to 8 bits in byte mode.
- R6: Index 6 bits [2:0] hold a trigger code n, and the threshold is 2^n words (codes 5 to 7 mean 32). Status bit 0 is set while the receive word count is at or above the threshold, but only when control bit 19 is 1.
- R7: The status register (index 1) is cleared bit by bit by writing 1. Writing 0 leaves a bit unchanged.
- R8: Status bit 12 (overflow) is set when rxPush arrives while the receive FIFO is full. Status bit 13 (underrun) is set when txPopReq arrives while the transmit FIFO is empty.
- R9: Status bit 9 is set when txShiftDone pulses with the transmit FIFO empty. Bit 8 is set on commDone. Bit 4 is set when the engine takes the last transmit word.
- R10: irq is high exactly when some status bit is set and its enable at the same position in the control register is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (pops on the receive window) |
| regAddr | input | 3 | Register word index |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, combinational from regAddr |
| txPopReq | input | 1 | Engine takes the current transmit word |
| txWord | output | 16 | Oldest transmit word (0 when empty) |
| txValid | output | 1 | Transmit FIFO not empty |
| rxPush | input | 1 | Engine delivers a received word |
| rxWord | input | 16 | Received word |
| txShiftDone | input | 1 | Engine finished shifting a word |
| commDone | input | 1 | Engine finished a communication |
| irq | output | 1 | Level interrupt |

## Verification
The bench fills each FIFO one word past its capacity in both word sizes. A design that counted capacity in entries would accept 32 words in 16-bit mode, and a design that reported entries would show a level of 16 where 32 is expected. The trigger test stops one word short of the threshold, then reaches it, then flushes and clears the flag. This separates an off-by-one compare and an ungated flag from correct behaviour. The write-1-clear test writes zeros and then a single one, and the interrupt test enables the wrong bit before the right one. A design that cleared on any write, or that ORed the status without masking, fails there. The bench also reads the empty window and checks for zero, and it checks transmit-end both with and without data left in the FIFO.

// File: rtl/sbi_pkg.sv
package sbi_pkg;
  localparam int FIFO_BYTES = 32;
  localparam int WORD_W     = 16;
  localparam int REG_W      = 32;
  localparam int TRG_W      = 3;

  // status / enable bit positions
  localparam int B_UNDER = 13;
  localparam int B_OVER  = 12;
  localparam int B_TXEND = 9;
  localparam int B_COMM  = 8;
  localparam int B_TXTRG = 4;
  localparam int B_RXTRG = 0;
  localparam logic [REG_W-1:0] EVT_MASK = 32'h0000_3311;

  // control-only bits
  localparam int C_TRGEN = 19;
  localparam int C_WIDE  = 24;

  // register word indices
  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_STAT  = 3'd1;
  localparam logic [2:0] A_RXLVL = 3'd2;
  localparam logic [2:0] A_TXLVL = 3'd3;
  localparam logic [2:0] A_RXWIN = 3'd4;
  localparam logic [2:0] A_TXWIN = 3'd5;
  localparam logic [2:0] A_TRG   = 3'd6;

  typedef struct packed {
    logic              txPush;
    logic              txFlush;
    logic              rxPop;
    logic              rxFlush;
    logic              wide;
    logic [WORD_W-1:0] wrWord;
  } strobe_t;
endpackage

// File: rtl/sbi_fifo_core.sv
module sbi_fifo_core #(
  parameter int DEPTH = 32,
  parameter int W     = 16,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          flush,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  input  logic [CW-1:0] capWords,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic          doPush, doPop;

  assign full   = (count >= capWords);
  assign empty  = (count == '0);
  assign doPush = push && !full && !flush;
  assign doPop  = pop && !empty && !flush;
  assign dout   = empty ? '0 : mem[rdPtr];

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= din;
  end
endmodule

// File: rtl/sbi_datapath.sv
module sbi_datapath import sbi_pkg::*; #(
  parameter int DEPTH = FIFO_BYTES,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              txPopReq,
  input  logic              rxPush,
  input  logic [WORD_W-1:0] rxWord,
  output logic [WORD_W-1:0] txWord,
  output logic              txValid,
  output logic [WORD_W-1:0] rxHead,
  output logic [CW-1:0]     txCount,
  output logic [CW-1:0]     rxCount,
  output logic              rxFull
);
  logic [CW-1:0]     capWords;
  logic [WORD_W-1:0] rxIn;
  logic              txFull, txEmpty, rxEmpty;

  // capacity is fixed in bytes; wide entries take two
  assign capWords = strb.wide ? CW'(DEPTH / 2) : CW'(DEPTH);
  assign rxIn     = strb.wide ? rxWord : {8'h00, rxWord[7:0]};
  assign txValid  = !txEmpty;

  sbi_fifo_core #(.DEPTH(DEPTH), .W(WORD_W)) u_txFifo (
    .clk(clk), .rstN(rstN), .flush(strb.txFlush), .push(strb.txPush),
    .pop(txPopReq), .din(strb.wrWord), .capWords(capWords),
    .dout(txWord), .count(txCount), .full(txFull), .empty(txEmpty)
  );

  sbi_fifo_core #(.DEPTH(DEPTH), .W(WORD_W)) u_rxFifo (
    .clk(clk), .rstN(rstN), .flush(strb.rxFlush), .push(rxPush),
    .pop(strb.rxPop), .din(rxIn), .capWords(capWords),
    .dout(rxHead), .count(rxCount), .full(rxFull), .empty(rxEmpty)
  );
endmodule

// File: rtl/sbi_control.sv
module sbi_control import sbi_pkg::*; #(
  parameter int DEPTH = FIFO_BYTES,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int TW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [2:0]        regAddr,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata,
  input  logic [CW-1:0]     txCount,
  input  logic [CW-1:0]     rxCount,
  input  logic [WORD_W-1:0] rxHead,
  input  logic              rxFull,
  input  logic              txPopReq,
  input  logic              rxPush,
  input  logic              txShiftDone,
  input  logic              commDone,
  output strobe_t           strb,
  output logic              irq,
  output logic [REG_W-1:0]  statusQ,
  output logic [REG_W-1:0]  ctrlQ
);
  localparam logic [REG_W-1:0] CTRL_MASK =
    EVT_MASK | (REG_W'(1) << C_TRGEN) | (REG_W'(1) << C_WIDE);

  logic [TRG_W-1:0] trgQ;
  logic [CW:0]      thrWords, txBytes, rxBytes;
  logic [REG_W-1:0] setVec, clrVec;
  logic             wrCtrl, wrStat, wrTrg;

  assign wrCtrl = regWrEn && (regAddr == A_CTRL);
  assign wrStat = regWrEn && (regAddr == A_STAT);
  assign wrTrg  = regWrEn && (regAddr == A_TRG);

  always_comb begin
    strb.txPush  = regWrEn && (regAddr == A_TXWIN);
    strb.txFlush = regWrEn && (regAddr == A_TXLVL);
    strb.rxFlush = regWrEn && (regAddr == A_RXLVL);
    strb.rxPop   = regRdEn && (regAddr == A_RXWIN);
    strb.wide    = ctrlQ[C_WIDE];
    strb.wrWord  = ctrlQ[C_WIDE] ? regWdata[WORD_W-1:0] : {8'h00, regWdata[7:0]};
  end

  // byte-count view of the word counts
  assign txBytes = ctrlQ[C_WIDE] ? {txCount, 1'b0} : {1'b0, txCount};
  assign rxBytes = ctrlQ[C_WIDE] ? {rxCount, 1'b0} : {1'b0, rxCount};

  always_comb begin
    if (trgQ >= TRG_W'(TW)) thrWords = (CW+1)'(DEPTH);
    else                    thrWords = (CW+1)'(1) << trgQ;
  end

  always_comb begin
    setVec          = '0;
    setVec[B_UNDER] = txPopReq && (txCount == '0);
    setVec[B_OVER]  = rxPush && rxFull;
    setVec[B_TXEND] = txShiftDone && (txCount == '0);
    setVec[B_COMM]  = commDone;
    setVec[B_TXTRG] = txPopReq && (txCount == CW'(1));
    setVec[B_RXTRG] = ctrlQ[C_TRGEN] && ({1'b0, rxCount} >= thrWords);
    clrVec          = wrStat ? (regWdata & EVT_MASK) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ   <= '0;
      statusQ <= '0;
      trgQ    <= '0;
    end else begin
      if (wrCtrl) ctrlQ <= regWdata & CTRL_MASK;
      if (wrTrg)  trgQ  <= regWdata[TRG_W-1:0];
      statusQ <= (statusQ & ~clrVec) | setVec;
    end
  end

  assign irq = |(statusQ & ctrlQ & EVT_MASK);

  always_comb begin
    case (regAddr)
      A_CTRL:  regRdata = ctrlQ;
      A_STAT:  regRdata = statusQ;
      A_RXLVL: regRdata = REG_W'(rxBytes);
      A_TXLVL: regRdata = REG_W'(txBytes);
      A_RXWIN: regRdata = REG_W'(rxHead);
      A_TRG:   regRdata = REG_W'(trgQ);
      default: regRdata = '0;
    endcase
  end
endmodule

// File: rtl/serbuf_irq_unit.sv
module serbuf_irq_unit import sbi_pkg::*; #(
  parameter int DEPTH = FIFO_BYTES,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [2:0]        regAddr,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata,
  input  logic              txPopReq,
  output logic [WORD_W-1:0] txWord,
  output logic              txValid,
  input  logic              rxPush,
  input  logic [WORD_W-1:0] rxWord,
  input  logic              txShiftDone,
  input  logic              commDone,
  output logic              irq
);
  strobe_t           strb;
  logic [CW-1:0]     txCount, rxCount;
  logic [WORD_W-1:0] rxHead;
  logic              rxFull;
  logic [REG_W-1:0]  statusQ, ctrlQ;

  sbi_control #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .txCount(txCount), .rxCount(rxCount), .rxHead(rxHead), .rxFull(rxFull),
    .txPopReq(txPopReq), .rxPush(rxPush), .txShiftDone(txShiftDone),
    .commDone(commDone), .strb(strb), .irq(irq), .statusQ(statusQ),
    .ctrlQ(ctrlQ)
  );

  sbi_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .txPopReq(txPopReq),
    .rxPush(rxPush), .rxWord(rxWord), .txWord(txWord), .txValid(txValid),
    .rxHead(rxHead), .txCount(txCount), .rxCount(rxCount), .rxFull(rxFull)
  );
endmodule

// File: rtl/sbi_checker.sv
module sbi_checker import sbi_pkg::*; #(
  parameter int DEPTH = FIFO_BYTES,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWrEn,
  input logic [2:0]       regAddr,
  input logic [REG_W-1:0] regWdata,
  input logic             txPopReq,
  input logic             rxPush,
  input logic [CW-1:0]    txCount,
  input logic [CW-1:0]    rxCount,
  input logic             rxFull,
  input logic [REG_W-1:0] statusQ
);
  p_level_cap_r1: assert property (@(posedge clk) disable iff (!rstN)
    (txCount <= CW'(DEPTH)) && (rxCount <= CW'(DEPTH)));

  p_drop_full_r1: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == A_TXWIN && txCount == CW'(DEPTH) && !txPopReq)
    |=> (txCount == CW'(DEPTH)));

  p_flush_tx_r3: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == A_TXLVL) |=> (txCount == '0));

  p_flush_rx_r3: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == A_RXLVL) |=> (rxCount == '0));

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (statusQ[B_OVER] && !(regWrEn && regAddr == A_STAT && regWdata[B_OVER]))
    |=> statusQ[B_OVER]);

  p_overflow_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rxPush && rxFull) |=> statusQ[B_OVER]);

  p_underrun_r8: assert property (@(posedge clk) disable iff (!rstN)
    (txPopReq && txCount == '0) |=> statusQ[B_UNDER]);
endmodule

bind serbuf_irq_unit sbi_checker #(.DEPTH(DEPTH)) u_sbiChk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWdata(regWdata), .txPopReq(txPopReq), .rxPush(rxPush),
  .txCount(txCount), .rxCount(rxCount), .rxFull(rxFull), .statusQ(statusQ)
);

// File: tb/tb_serbuf_irq_unit.sv
module tb_serbuf_irq_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        txPopReq = 1'b0;
  logic [15:0] txWord;
  logic        txValid;
  logic        rxPush = 1'b0;
  logic [15:0] rxWord = '0;
  logic        txShiftDone = 1'b0, commDone = 1'b0;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  localparam logic [31:0] WIDE  = 32'h0100_0000;
  localparam logic [31:0] TRGEN = 32'h0008_0000;

  always #2.5 clk = ~clk;

  serbuf_irq_unit dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .txPopReq(txPopReq), .txWord(txWord), .txValid(txValid),
    .rxPush(rxPush), .rxWord(rxWord), .txShiftDone(txShiftDone),
    .commDone(commDone), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); regWrEn = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); regRdEn = 1'b1; regAddr = a;
    #1 d = regRdata;
    @(negedge clk); regRdEn = 1'b0;
  endtask

  task automatic engPop();
    @(negedge clk); txPopReq = 1'b1;
    @(negedge clk); txPopReq = 1'b0;
  endtask

  task automatic engPush(input logic [15:0] w);
    @(negedge clk); rxPush = 1'b1; rxWord = w;
    @(negedge clk); rxPush = 1'b0;
  endtask

  task automatic pulseShift();
    @(negedge clk); txShiftDone = 1'b1;
    @(negedge clk); txShiftDone = 1'b0;
  endtask

  task automatic pulseComm();
    @(negedge clk); commDone = 1'b1;
    @(negedge clk); commDone = 1'b0;
  endtask

  task automatic testReset();
    logic [31:0] v;
    check("R10 irq after reset", {31'b0, irq}, 32'h0);
    rd(3'd1, v); check("R7 status after reset", v, 32'h0);
    rd(3'd2, v); check("R2 rx level after reset", v, 32'h0);
    rd(3'd3, v); check("R2 tx level after reset", v, 32'h0);
  endtask

  task automatic testBytePush();
    logic [31:0] v;
    wr(3'd0, 32'h0);
    wr(3'd5, 32'h1A5);
    wr(3'd5, 32'h3C);
    rd(3'd3, v); check("R2 tx level two bytes", v, 32'd2);
    @(negedge clk);
    check("R4 low byte pushed", {16'b0, txWord}, 32'hA5);
    engPop();
    check("R4 second word in order", {16'b0, txWord}, 32'h3C);
    engPop();
    check("R4 tx empty after pops", {31'b0, txValid}, 32'h0);
    wr(3'd1, 32'hFFFF_FFFF);
  endtask

  task automatic testByteCapacity();
    logic [31:0] v;
    for (int i = 0; i < 33; i++) wr(3'd5, 32'(i + 1));
    rd(3'd3, v); check("R1 byte-mode tx fills to 32", v, 32'd32);
    check("R1 oldest word kept", {16'b0, txWord}, 32'h1);
    wr(3'd3, 32'h0);
    rd(3'd3, v); check("R3 tx flush by level write", v, 32'd0);
  endtask

  task automatic testWideCapacity();
    logic [31:0] v;
    wr(3'd0, WIDE);
    for (int i = 0; i < 17; i++) wr(3'd5, 32'hABCD_1234 + 32'(i));
    rd(3'd3, v); check("R1 R2 wide tx holds 16 words = 32 bytes", v, 32'd32);
    check("R4 wide push keeps 16 bits", {16'b0, txWord}, 32'h1234);
    wr(3'd3, 32'h5);
  endtask

  task automatic testRx();
    logic [31:0] v;
    engPush(16'hBEEF);
    engPush(16'h0102);
    rd(3'd2, v); check("R2 wide rx level in bytes", v, 32'd4);
    rd(3'd4, v); check("R5 first rx word", v, 32'hBEEF);
    rd(3'd4, v); check("R5 second rx word", v, 32'h0102);
    rd(3'd4, v); check("R5 empty read returns zero", v, 32'h0);
    wr(3'd0, 32'h0);
    engPush(16'h01C7);
    rd(3'd2, v); check("R2 byte rx level", v, 32'd1);
    rd(3'd4, v); check("R5 byte mode masks rx word", v, 32'hC7);
  endtask

  task automatic testTrigger();
    logic [31:0] v;
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd6, 32'd2);
    wr(3'd0, TRGEN);
    for (int i = 0; i < 3; i++) engPush(16'(i));
    rd(3'd1, v); check("R6 below threshold 4", v & 32'h1, 32'h0);
    engPush(16'h9);
    rd(3'd1, v); check("R6 threshold 4 reached", v & 32'h1, 32'h1);
    wr(3'd2, 32'h0);
    wr(3'd1, 32'h1);
    rd(3'd1, v); check("R6 R7 cleared after flush", v & 32'h1, 32'h0);
    wr(3'd6, 32'd0);
    wr(3'd0, 32'h0);
    engPush(16'h1);
    rd(3'd1, v); check("R6 gated off by enable", v & 32'h1, 32'h0);
    wr(3'd0, TRGEN);
    @(negedge clk);
    rd(3'd1, v); check("R6 code 0 means one word", v & 32'h1, 32'h1);
    wr(3'd0, 32'h0);
    wr(3'd2, 32'h0);
    wr(3'd1, 32'hFFFF_FFFF);
  endtask

  task automatic testErrors();
    logic [31:0] v;
    for (int i = 0; i < 33; i++) engPush(16'(i));
    rd(3'd1, v); check("R8 overflow on full rx", v & 32'h1000, 32'h1000);
    rd(3'd2, v); check("R1 rx keeps 32 bytes", v, 32'd32);
    wr(3'd2, 32'h0);
    engPop();
    rd(3'd1, v); check("R8 underrun on empty tx", v & 32'h3000, 32'h3000);
    wr(3'd1, 32'h0);
    rd(3'd1, v); check("R7 writing zero keeps bits", v & 32'h3000, 32'h3000);
    wr(3'd1, 32'h1000);
    rd(3'd1, v); check("R7 write one clears only that bit", v & 32'h3000, 32'h2000);
    wr(3'd1, 32'hFFFF_FFFF);
  endtask

  task automatic testEvents();
    logic [31:0] v;
    wr(3'd5, 32'h11);
    pulseShift();
    rd(3'd1, v); check("R9 no tx-end with data left", v, 32'h0);
    engPop();
    rd(3'd1, v); check("R9 last word taken sets bit 4", v, 32'h10);
    pulseShift();
    rd(3'd1, v); check("R9 tx-end when empty", v, 32'h210);
    pulseComm();
    rd(3'd1, v); check("R9 communication end", v, 32'h310);
    wr(3'd1, 32'hFFFF_FFFF);
  endtask

  task automatic testIrq();
    engPop();
    wr(3'd0, 32'h1000);
    @(negedge clk);
    check("R10 other enable keeps irq low", {31'b0, irq}, 32'h0);
    wr(3'd0, 32'h2000);
    @(negedge clk);
    check("R10 matching enable raises irq", {31'b0, irq}, 32'h1);
    wr(3'd1, 32'h2000);
    @(negedge clk);
    check("R10 irq drops after clear", {31'b0, irq}, 32'h0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBytePush();
    testByteCapacity();
    testWideCapacity();
    testRx();
    testTrigger();
    testErrors();
    testEvents();
    testIrq();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule